// File: doc/BRIEF.md
# NAND Hamming ECC Engine

This engine computes single-error-correcting Hamming parity for NAND page data in steps of 512 bytes. Each step is handled as two 256-byte halves, and each half has its own accumulator. A half collects 16 line-parity bits, which depend on each byte's address within the half, and 6 column-parity bits, which depend on bit positions within the bytes. With one correctable bit per half, a step can correct up to two single-bit errors. Software then stores six ECC bytes per step.

The engine watches every byte strobe that passes through the NAND data port. Software controls it by writing byte-wide mode codes:

- A clear code empties both accumulators and arms the discard of one dummy byte.
- An accumulate code starts folding bytes into the parity.
- A result code makes the data port return the ECC in three 16-bit reads.
- Any other code, such as the plain data-mode code, returns the port to normal transfers.

The two halves' ECC bytes are interleaved across the three result words. Every parity bit is stored inverted, so an erased page of all 0xFF bytes gives ECC bytes that are all ones.

Top module: `nand_ecc_engine`

## Requirements
- R1: After rst_ni is released, ecc_sel_o is 0 and no dummy byte is pending. Both accumulators are cleared, so entering result mode reads 0xFFFF from all three words.
- R2: A mode write of 0xF4 clears both halves, the byte counter and the read pointer, and arms the dummy discard. In the next cycle, ecc_word_o reads 0xFFFF.
- R3: The first byte strobe after a 0xF4 write is never folded into the parity, whatever the mode is at that time. That strobe also ends the dummy discard.
- R4: A mode write of 0xD4 raises ecc_sel_o in the next cycle and points to word 0. The result words are packed as follows, with lp0/cp0 for the first half and lp1/cp1 for the second:
  - word 0 = {~lp0[15:8], ~lp0[7:0]}
  - word 1 = {~lp1[7:0], ~cp0[5:0], 2'b11}
  - word 2 = {~cp1[5:0], 2'b11, ~lp1[15:8]}
- R5: In result mode, each word_rd_i moves the pointer through words 0, 1, 2 and then back to 0. Any mode write puts the pointer back to word 0.
- R6: Any mode code other than 0xF4, 0xB4 and 0xD4 (for example the data code 0x94) drops ecc_sel_o in the next cycle and stops accumulation. The parity already collected is kept.
- R7: The parity bits are defined as follows, and ecc_word_o holds their complements:
  - lp[2k+1] is the XOR of all bits of the folded bytes whose in-half address has bit k set.
  - lp[2k] is the same XOR over the bytes whose address bit k is clear.
  - cp[2g+1] is the XOR, over all folded bytes, of the data bits whose bit index has bit g set.
  - cp[2g] is the same XOR over the data bits whose bit index has bit g clear.
- R8: A 9-bit counter of folded bytes selects the half: counts 0 to 255 go to the first half and counts 256 to 511 to the second. Bytes in one half leave the other half's bits unchanged.
- R9: Byte strobes outside accumulate mode leave the parity unchanged. The only exception is the dummy-discard effect of R3.
- R10: A byte strobe in the same cycle as a mode write is handled as follows:
  - With any code other than 0xF4, the byte is judged by the mode in force before the write.
  - With 0xF4, the clear wins, and the byte is neither folded nor taken as the dummy.
  - A word_rd_i in the same cycle as a mode write does not advance the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_i | input | 8 | Mode code written |
| byte_vld_i | input | 1 | A byte passes the NAND data port this cycle |
| byte_i | input | 8 | The byte passing the data port |
| word_rd_i | input | 1 | 16-bit read of the data port in result mode |
| ecc_sel_o | output | 1 | Result mode active; the data port returns ecc_word_o |
| ecc_word_o | output | 16 | Result word selected by the read pointer |

## Verification
A mode write can land in the same cycle as a byte strobe, and likewise in the same cycle as a result-word read. The bench provokes both cases:

- It drives the data code while a byte strobe is active during accumulation. That byte should be folded.
- It drives the clear code together with a byte strobe. That byte should be neither folded nor taken as the dummy, so the byte after it becomes the dummy.
- It drives the accumulate code together with the pending dummy byte. That byte should be discarded.
- It drives a mode write together with a word read. The pointer should return to word 0.

Each outcome is judged afterwards from the three result words, compared against parity that the bench computes itself.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int unsigned HALF_AW    = 8;
  localparam int unsigned STEP_AW    = HALF_AW + 1;
  localparam int unsigned LP_W       = 2 * HALF_AW;
  localparam int unsigned CP_W       = 6;
  localparam int unsigned NUM_HALVES = 2;
  localparam int unsigned NUM_WORDS  = 3;
  localparam int unsigned PTR_W      = 2;
  localparam int unsigned WORD_W     = 16;

  localparam logic [7:0] MODE_CLR  = 8'hF4;
  localparam logic [7:0] MODE_ACC  = 8'hB4;
  localparam logic [7:0] MODE_RES  = 8'hD4;
  localparam logic [7:0] MODE_DATA = 8'h94;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_RES  = 2'd2
  } eng_st_e;

  typedef struct packed {
    logic [LP_W-1:0] lp;
    logic [CP_W-1:0] cp;
  } half_ecc_t;
endpackage

// File: rtl/ecc_mode_ctrl.sv
module ecc_mode_ctrl
  import nand_ecc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_we_i,
  input  logic [7:0]         mode_i,
  input  logic               byte_vld_i,
  input  logic               word_rd_i,
  output logic               clr_o,
  output logic               fold_o,
  output logic               half_o,
  output logic [HALF_AW-1:0] addr_o,
  output logic [PTR_W-1:0]   ptr_o,
  output logic               res_mode_o,
  output logic               acc_mode_o,
  output logic               dummy_pend_o
);
  localparam logic [PTR_W-1:0] LAST_WORD = PTR_W'(NUM_WORDS - 1);

  eng_st_e            st_q;
  logic               dummy_q;
  logic [STEP_AW-1:0] cnt_q;
  logic [PTR_W-1:0]   ptr_q;
  logic               is_clr;

  always_comb begin
    is_clr = mode_we_i && (mode_i == MODE_CLR);
    clr_o  = is_clr;
    fold_o = byte_vld_i && (st_q == ST_ACC) && !dummy_q && !is_clr;
    half_o = cnt_q[STEP_AW-1];
    addr_o = cnt_q[HALF_AW-1:0];
    ptr_o  = ptr_q;
    res_mode_o   = (st_q == ST_RES);
    acc_mode_o   = (st_q == ST_ACC);
    dummy_pend_o = dummy_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      dummy_q <= 1'b0;
      cnt_q   <= '0;
      ptr_q   <= '0;
    end else if (is_clr) begin
      st_q    <= ST_IDLE;
      dummy_q <= 1'b1;
      cnt_q   <= '0;
      ptr_q   <= '0;
    end else begin
      if (byte_vld_i && dummy_q) dummy_q <= 1'b0;
      if (fold_o) cnt_q <= cnt_q + 1'b1;
      if (mode_we_i) begin
        ptr_q <= '0;
        unique case (mode_i)
          MODE_ACC: st_q <= ST_ACC;
          MODE_RES: st_q <= ST_RES;
          default:  st_q <= ST_IDLE;
        endcase
      end else if (word_rd_i && st_q == ST_RES) begin
        ptr_q <= (ptr_q == LAST_WORD) ? '0 : ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ecc_half_acc.sv
module ecc_half_acc
  import nand_ecc_pkg::*;
#(
  parameter int unsigned AW = HALF_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          fold_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    byte_i,
  output half_ecc_t     ecc_o
);
  localparam int unsigned LW = 2 * AW;
  localparam int unsigned NG = CP_W / 2;

  logic [LW-1:0]   lp_q, lp_d;
  logic [CP_W-1:0] cp_q, cp_d;
  logic            bpar;

  always_comb begin
    bpar = ^byte_i;
    for (int k = 0; k < AW; k++) begin
      lp_d[2*k]   = lp_q[2*k]   ^ (bpar & ~addr_i[k]);
      lp_d[2*k+1] = lp_q[2*k+1] ^ (bpar &  addr_i[k]);
    end
    for (int g = 0; g < NG; g++) begin
      logic ev, od;
      ev = 1'b0;
      od = 1'b0;
      for (int j = 0; j < 8; j++) begin
        if (((j >> g) & 1) != 0) od = od ^ byte_i[j];
        else                     ev = ev ^ byte_i[j];
      end
      cp_d[2*g]   = cp_q[2*g]   ^ ev;
      cp_d[2*g+1] = cp_q[2*g+1] ^ od;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lp_q <= '0;
      cp_q <= '0;
    end else if (clr_i) begin
      lp_q <= '0;
      cp_q <= '0;
    end else if (fold_i) begin
      lp_q <= lp_d;
      cp_q <= cp_d;
    end
  end

  // stored inverted: erased page reads as all ones
  assign ecc_o.lp = ~lp_q;
  assign ecc_o.cp = ~cp_q;
endmodule

// File: rtl/ecc_result_pack.sv
module ecc_result_pack
  import nand_ecc_pkg::*;
(
  input  half_ecc_t         lo_i,
  input  half_ecc_t         hi_i,
  input  logic [PTR_W-1:0]  ptr_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned LPB = LP_W / 2;

  logic [WORD_W-1:0] words [NUM_WORDS];

  always_comb begin
    words[0] = {lo_i.lp[LP_W-1:LPB], lo_i.lp[LPB-1:0]};
    words[1] = {hi_i.lp[LPB-1:0], lo_i.cp, 2'b11};
    words[2] = {hi_i.cp, 2'b11, hi_i.lp[LP_W-1:LPB]};
    word_o   = words[0];
    for (int w = 0; w < NUM_WORDS; w++)
      if (ptr_i == PTR_W'(w)) word_o = words[w];
  end
endmodule

// File: rtl/nand_ecc_engine.sv
module nand_ecc_engine
  import nand_ecc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [7:0]        mode_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              word_rd_i,
  output logic              ecc_sel_o,
  output logic [WORD_W-1:0] ecc_word_o
);
  logic               clr, fold, half;
  logic [HALF_AW-1:0] addr;
  logic [PTR_W-1:0]   rd_ptr;
  logic               acc_mode, dummy_pend;
  logic [NUM_HALVES-1:0] fold_h;
  half_ecc_t          half_ecc [NUM_HALVES];

  ecc_mode_ctrl i_ctrl (
    .clk_i, .rst_ni, .mode_we_i, .mode_i, .byte_vld_i, .word_rd_i,
    .clr_o(clr), .fold_o(fold), .half_o(half), .addr_o(addr),
    .ptr_o(rd_ptr), .res_mode_o(ecc_sel_o), .acc_mode_o(acc_mode),
    .dummy_pend_o(dummy_pend)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    assign fold_h[h] = fold && (int'(half) == h);
    ecc_half_acc #(.AW(HALF_AW)) i_acc (
      .clk_i, .rst_ni, .clr_i(clr), .fold_i(fold_h[h]),
      .addr_i(addr), .byte_i, .ecc_o(half_ecc[h])
    );
  end

  ecc_result_pack i_pack (
    .lo_i(half_ecc[0]), .hi_i(half_ecc[1]), .ptr_i(rd_ptr), .word_o(ecc_word_o)
  );
endmodule

// File: rtl/nand_ecc_engine_chk.sv
module nand_ecc_engine_chk
  import nand_ecc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_we_i,
  input logic [7:0]        mode_i,
  input logic              byte_vld_i,
  input logic              word_rd_i,
  input logic              ecc_sel_o,
  input logic [WORD_W-1:0] ecc_word_o,
  input logic [PTR_W-1:0]  rd_ptr,
  input logic              acc_mode,
  input logic              dummy_pend
);
  a_r2_clear_words: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i && mode_i == MODE_CLR |=> ecc_word_o == 16'hFFFF && dummy_pend);

  a_r3_dummy_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_i && dummy_pend && !mode_we_i && !word_rd_i |=> $stable(ecc_word_o) && !dummy_pend);

  a_r4_result_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i && mode_i == MODE_RES |=> ecc_sel_o && rd_ptr == '0);

  a_r5_ptr_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_sel_o && word_rd_i && !mode_we_i && rd_ptr == PTR_W'(NUM_WORDS - 1) |=> rd_ptr == '0);

  a_r5_ptr_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> rd_ptr == '0);

  a_r6_leave_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i && mode_i == MODE_DATA |=> !ecc_sel_o && !acc_mode);

  a_r9_idle_bytes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_i && !acc_mode && !mode_we_i && !word_rd_i |=> $stable(ecc_word_o));
endmodule

bind nand_ecc_engine nand_ecc_engine_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_we_i(mode_we_i), .mode_i(mode_i),
  .byte_vld_i(byte_vld_i), .word_rd_i(word_rd_i), .ecc_sel_o(ecc_sel_o),
  .ecc_word_o(ecc_word_o), .rd_ptr(rd_ptr), .acc_mode(acc_mode),
  .dummy_pend(dummy_pend)
);

// File: tb/test_nand_ecc_engine.sv
module test_nand_ecc_engine;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic mode_we_i = 1'b0, byte_vld_i = 1'b0, word_rd_i = 1'b0;
  logic [7:0] mode_i = 8'h00, byte_i = 8'h00;
  logic ecc_sel_o;
  logic [15:0] ecc_word_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model
  logic [15:0] m_lp [2];
  logic [5:0]  m_cp [2];
  logic [8:0]  m_cnt;
  bit          m_dummy, m_acc;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_ecc_engine i_nand_ecc_engine (
    .clk_i(clk), .rst_ni, .mode_we_i, .mode_i, .byte_vld_i, .byte_i,
    .word_rd_i, .ecc_sel_o, .ecc_word_o
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(int w);
    case (w)
      0:       return ~m_lp[0];
      1:       return {~m_lp[1][7:0], ~m_cp[0], 2'b11};
      default: return {~m_cp[1], 2'b11, ~m_lp[1][15:8]};
    endcase
  endfunction

  task automatic m_clear();
    for (int h = 0; h < 2; h++) begin m_lp[h] = '0; m_cp[h] = '0; end
    m_cnt = '0;
  endtask

  task automatic m_fold(logic [7:0] b);
    int h;
    logic p;
    h = int'(m_cnt[8]);
    p = ^b;
    for (int k = 0; k < 8; k++)
      if (m_cnt[k]) m_lp[h][2*k+1] ^= p; else m_lp[h][2*k] ^= p;
    m_cp[h][0] ^= ^(b & 8'h55);
    m_cp[h][1] ^= ^(b & 8'hAA);
    m_cp[h][2] ^= ^(b & 8'h33);
    m_cp[h][3] ^= ^(b & 8'hCC);
    m_cp[h][4] ^= ^(b & 8'h0F);
    m_cp[h][5] ^= ^(b & 8'hF0);
    m_cnt++;
  endtask

  task automatic m_byte(logic [7:0] b);
    if (m_dummy) m_dummy = 1'b0;
    else if (m_acc) m_fold(b);
  endtask

  task automatic mode_wr(logic [7:0] code);
    mode_we_i = 1'b1; mode_i = code;
    @(negedge clk);
    mode_we_i = 1'b0;
    if (code == 8'hF4) begin m_clear(); m_dummy = 1'b1; m_acc = 1'b0; end
    else m_acc = (code == 8'hB4);
  endtask

  task automatic send(logic [7:0] b);
    byte_vld_i = 1'b1; byte_i = b;
    @(negedge clk);
    byte_vld_i = 1'b0;
    m_byte(b);
  endtask

  task automatic read_result(string req);
    mode_wr(8'hD4);
    chk({req, " R4 sel"}, {15'd0, ecc_sel_o}, 16'd1);
    for (int w = 0; w < 3; w++) begin
      chk({req, " R4/R7 word"}, ecc_word_o, exp_word(w));
      word_rd_i = 1'b1;
      @(negedge clk);
      word_rd_i = 1'b0;
    end
    chk({req, " R5 wrap to word0"}, ecc_word_o, exp_word(0));
    mode_wr(8'h94);
    chk({req, " R6 sel low"}, {15'd0, ecc_sel_o}, 16'd0);
  endtask

  task automatic start_step();
    mode_wr(8'hF4);
    send(8'h5A);  // dummy
    mode_wr(8'hB4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    m_clear(); m_dummy = 1'b0; m_acc = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sel after reset", {15'd0, ecc_sel_o}, 16'd0);
    chk("R1 word after reset", ecc_word_o, 16'hFFFF);
    read_result("R1");

    // R7 erased page
    start_step();
    for (int i = 0; i < 512; i++) send(8'hFF);
    read_result("R7 erased");
    chk("R7 erased w0", exp_word(0), 16'hFFFF);

    // R7 zero page
    start_step();
    for (int i = 0; i < 512; i++) send(8'h00);
    read_result("R7 zeros");

    // R7 pseudo-random pages
    lfsr = 8'h1D;
    for (int pg = 0; pg < 2; pg++) begin
      start_step();
      for (int i = 0; i < 512; i++) begin
        send(lfsr ^ 8'(i));
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      end
      read_result("R7 lfsr");
    end

    // R7/R8 single bit sweep over addresses and bit positions
    for (int k = 0; k < 40; k++) begin
      int a, b;
      a = (k * 37 + k / 8) % 512;
      b = k % 8;
      start_step();
      for (int i = 0; i < 512; i++) send(i == a ? (8'hFF ^ (8'h01 << b)) : 8'hFF);
      read_result("R7 R8 sweep");
    end

    // R8 first half only: second half fields untouched
    start_step();
    for (int i = 0; i < 100; i++) send(8'(i * 3 + 1));
    read_result("R8 half0");
    chk("R8 half1 lp low", {8'h00, exp_word(1)[15:8]}, 16'h00FF);
    chk("R8 half1 word2", exp_word(2), 16'hFFFF);

    // R3 dummy dropped even with accumulate written first
    mode_wr(8'hF4);
    mode_wr(8'hB4);
    send(8'h01);  // dummy, must be dropped
    chk("R3 dummy not folded", ecc_word_o, 16'hFFFF);
    send(8'h01);
    read_result("R3");

    // R9 bytes in data mode ignored
    send(8'h37); send(8'hC1);
    read_result("R9 after idle bytes");
    // R2 clear
    mode_wr(8'hB4);
    send(8'h80);
    mode_wr(8'hF4);
    chk("R2 cleared", ecc_word_o, 16'hFFFF);

    // R10 same-cycle cases
    send(8'h00);       // dummy
    mode_wr(8'hB4);
    send(8'h07);
    // data code with byte: byte judged by accumulate mode
    mode_we_i = 1'b1; mode_i = 8'h94; byte_vld_i = 1'b1; byte_i = 8'h0B;
    @(negedge clk);
    mode_we_i = 1'b0; byte_vld_i = 1'b0;
    m_fold(8'h0B); m_acc = 1'b0;
    read_result("R10 data+byte");
    // clear with byte: neither folded nor dummy
    mode_wr(8'hB4);
    send(8'h11);
    mode_we_i = 1'b1; mode_i = 8'hF4; byte_vld_i = 1'b1; byte_i = 8'h01;
    @(negedge clk);
    mode_we_i = 1'b0; byte_vld_i = 1'b0;
    m_clear(); m_dummy = 1'b1; m_acc = 1'b0;
    // accumulate with byte: byte is the dummy
    mode_we_i = 1'b1; mode_i = 8'hB4; byte_vld_i = 1'b1; byte_i = 8'h02;
    @(negedge clk);
    mode_we_i = 1'b0; byte_vld_i = 1'b0;
    m_dummy = 1'b0; m_acc = 1'b1;
    chk("R10 clear+byte dummy", ecc_word_o, 16'hFFFF);
    send(8'h04);
    send(8'hFE);
    read_result("R10 clear+byte");
    // mode write with word read: pointer back to word 0
    mode_wr(8'hD4);
    word_rd_i = 1'b1; @(negedge clk); word_rd_i = 1'b0;
    chk("R5 ptr at word1", ecc_word_o, exp_word(1));
    mode_we_i = 1'b1; mode_i = 8'hD4; word_rd_i = 1'b1;
    @(negedge clk);
    mode_we_i = 1'b0; word_rd_i = 1'b0;
    chk("R10 R5 write beats read", ecc_word_o, exp_word(0));
    mode_wr(8'h94);

    // R8 counter wrap after 512 bytes
    start_step();
    for (int i = 0; i < 515; i++) send(8'(i + 5));
    read_result("R8 wrap");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule